// File: doc/BRIEF.md
# Serial DAC Data and Strobe Shifter

This block feeds a group of four serial digital-to-analog converters from one shared bit clock and one shared strobe line. Each time a phase-cycle pulse arrives, the block arms itself. At the next falling edge of its DAC clock it captures a 24-bit strobe pattern and one 24-bit data word per channel. It then shifts all five words out together, most significant bit first, one bit per DAC clock period. Bits change on the falling DAC clock edge, so the converters can sample on the rising edge. After the last bit, every serial line drops low and stays there until the next phase cycle.

The DAC clock comes from a free-running divider on the system clock. A power-of-two exponent selects the ratio, which lets the bit rate be matched to the converters (for example 4.9152 MHz). Each channel has its own invert control. When it is set, the channel's bit stream is complemented, which negates that converter's output. A strobe pattern of 0x7FFFC0 suits common converters. A phase-cycle pulse that arrives before the previous transfer has finished is dropped, and the drop is recorded in a sticky overrun flag.

Top module: `sdac_shifter`

## Requirements
- R1: After synchronous reset, dac_clk, dac_strobe, every dac_sdata bit and overrun are all 0.
- R2: dac_clk is a square wave with a period of 2^(div_sel+1) system clock cycles, high for half of that period.
- R3: After a phase_pulse accepted while idle, the next falling edge of dac_clk starts a transfer of exactly 24 bit times. Serial outputs change only on falling edges of dac_clk and hold steady across each rising edge.
- R4: During a transfer, dac_strobe carries strobe_pattern (captured at the start) with bit 23 in the first bit time and bit 0 in the last.
- R5: During the same 24 bit times, dac_sdata[c] carries channel c's word ch_data[24*c+23 : 24*c], captured at the start, with bit 23 first.
- R6: When ch_invert[c] is 1 at the start of a transfer, every bit on dac_sdata[c] is the complement of the word bit. When it is 0, the bits are sent unchanged.
- R7: At the falling dac_clk edge that ends the 24th bit time, dac_strobe and all dac_sdata lines go to 0 and stay 0 until the next accepted transfer starts.
- R8: A phase_pulse that arrives while a transfer is armed or in progress does not alter that transfer, and it sets overrun. Input changes made after the start of a transfer likewise do not alter it.
- R9: Once overrun is 1, it stays 1 until reset, and it rises only in the cycle after a phase_pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| div_sel | input | 3 | DAC clock divider exponent; period is 2^(div_sel+1) clocks |
| phase_pulse | input | 1 | One-cycle phase-cycle start pulse |
| strobe_pattern | input | 24 | Strobe word shared by the four channels |
| ch_data | input | 96 | Four 24-bit channel words, channel c at bits 24c+23:24c |
| ch_invert | input | 4 | Per-channel serial data complement control |
| dac_clk | output | 1 | Divided DAC bit clock |
| dac_strobe | output | 1 | Serial strobe line |
| dac_sdata | output | 4 | Serial data line per channel |
| overrun | output | 1 | Sticky flag: phase pulse arrived before transfer completed |

## Verification
On every cycle, the bound assertions check the following: serial lines are low whenever no transfer is running; serial outputs change only with a falling DAC clock; overrun never clears once set; and overrun rises only after a phase pulse. Other behaviours can be shown only by the bench's sweeps over divider settings, patterns and invert masks. These are the exact bit order, the lockstep of strobe and data, the complement applied per channel, the measured clock period, and the fact that a late pulse or late input change leaves the running transfer untouched.

// File: rtl/sdac_pkg.sv
package sdac_pkg;

    localparam int WORD_W         = 24;
    localparam int NUM_CH         = 4;
    localparam int DIV_W          = 3;
    localparam logic [WORD_W-1:0] STROBE_DEFAULT = 24'h7FFFC0;

    typedef enum logic [1:0] {
        XF_IDLE  = 2'd0,
        XF_ARMED = 2'd1,
        XF_SHIFT = 2'd2
    } xfer_state_e;

    typedef struct packed {
        logic load;
        logic shift;
        logic clear;
    } lane_ctl_t;

    // Mask of counter bits 0..sel inclusive
    function automatic logic [(2**DIV_W)-1:0] div_mask(input logic [DIV_W-1:0] sel);
        logic [(2**DIV_W)-1:0] one_hot;
        one_hot = '0;
        one_hot[sel] = 1'b1;
        return (one_hot << 1) - 1'b1 | one_hot;
    endfunction

endpackage

// File: rtl/sdac_clkdiv.sv
module sdac_clkdiv
    import sdac_pkg::*;
#(
    parameter int SEL_W = DIV_W,
    localparam int CNT_W = 2**SEL_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SEL_W-1:0] sel,
    output logic             bit_clk,
    output logic             fall_tick
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] mask;

    always_comb begin
        mask = '0;
        for (int i = 0; i < CNT_W; i++) begin
            mask[i] = (i <= int'(sel));
        end
    end

    // Counter wraps its low bits on this edge, so bit[sel] drops 1 -> 0
    assign fall_tick = ((cnt_q & mask) == mask);
    assign bit_clk   = cnt_q[sel];

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/sdac_ctrl.sv
module sdac_ctrl
    import sdac_pkg::*;
#(
    parameter int BITS = WORD_W,
    localparam int BC_W = $clog2(BITS)
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      phase_pulse,
    input  logic      tick,
    output lane_ctl_t ctl,
    output logic      busy,
    output logic      overrun
);
    xfer_state_e state_q;
    logic [BC_W-1:0] bit_q;
    logic last_bit;

    assign last_bit  = (bit_q == BC_W'(BITS - 1));
    assign busy      = (state_q != XF_IDLE);
    assign ctl.load  = (state_q == XF_ARMED) && tick;
    assign ctl.shift = (state_q == XF_SHIFT) && tick && !last_bit;
    assign ctl.clear = (state_q == XF_SHIFT) && tick && last_bit;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= XF_IDLE;
            bit_q   <= '0;
            overrun <= 1'b0;
        end else begin
            if (phase_pulse && busy) begin
                overrun <= 1'b1;
            end
            unique case (state_q)
                XF_IDLE: begin
                    if (phase_pulse) state_q <= XF_ARMED;
                end
                XF_ARMED: begin
                    if (tick) begin
                        state_q <= XF_SHIFT;
                        bit_q   <= '0;
                    end
                end
                XF_SHIFT: begin
                    if (tick) begin
                        if (last_bit) begin
                            state_q <= XF_IDLE;
                            bit_q   <= '0;
                        end else begin
                            bit_q <= bit_q + 1'b1;
                        end
                    end
                end
                default: state_q <= XF_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/sdac_lane.sv
module sdac_lane
    import sdac_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic         clk,
    input  logic         rst,
    input  lane_ctl_t    ctl,
    input  logic [W-1:0] word,
    input  logic         invert,
    output logic         sout
);
    logic [W-1:0] sr_q;

    assign sout = sr_q[W-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q <= '0;
        end else if (ctl.load) begin
            sr_q <= word ^ {W{invert}};
        end else if (ctl.shift) begin
            sr_q <= {sr_q[W-2:0], 1'b0};
        end else if (ctl.clear) begin
            sr_q <= '0;
        end
    end
endmodule

// File: rtl/sdac_shifter.sv
module sdac_shifter
    import sdac_pkg::*;
#(
    parameter int W   = WORD_W,
    parameter int CH  = NUM_CH,
    parameter int SW  = DIV_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [SW-1:0]   div_sel,
    input  logic            phase_pulse,
    input  logic [W-1:0]    strobe_pattern,
    input  logic [W*CH-1:0] ch_data,
    input  logic [CH-1:0]   ch_invert,
    output logic            dac_clk,
    output logic            dac_strobe,
    output logic [CH-1:0]   dac_sdata,
    output logic            overrun
);
    logic      fall_tick;
    logic      busy;
    lane_ctl_t ctl;

    sdac_clkdiv #(.SEL_W(SW)) u_div (
        .clk       (clk),
        .rst       (rst),
        .sel       (div_sel),
        .bit_clk   (dac_clk),
        .fall_tick (fall_tick)
    );

    sdac_ctrl #(.BITS(W)) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .phase_pulse (phase_pulse),
        .tick        (fall_tick),
        .ctl         (ctl),
        .busy        (busy),
        .overrun     (overrun)
    );

    sdac_lane #(.W(W)) u_strobe (
        .clk    (clk),
        .rst    (rst),
        .ctl    (ctl),
        .word   (strobe_pattern),
        .invert (1'b0),
        .sout   (dac_strobe)
    );

    for (genvar c = 0; c < CH; c++) begin : g_ch
        sdac_lane #(.W(W)) u_lane (
            .clk    (clk),
            .rst    (rst),
            .ctl    (ctl),
            .word   (ch_data[c*W +: W]),
            .invert (ch_invert[c]),
            .sout   (dac_sdata[c])
        );
    end
endmodule

// File: rtl/sdac_shifter_chk.sv
module sdac_shifter_chk #(
    parameter int CH = 4
) (
    input logic          clk,
    input logic          rst,
    input logic          phase_pulse,
    input logic          busy,
    input logic          dac_clk,
    input logic          dac_strobe,
    input logic [CH-1:0] dac_sdata,
    input logic          overrun
);
    // R7
    idle_low_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!dac_strobe && dac_sdata == '0));

    // R3
    change_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
        (!$stable(dac_strobe) || !$stable(dac_sdata)) |-> $fell(dac_clk));

    // R9
    overrun_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        overrun |=> overrun);

    // R8
    overrun_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(overrun) |-> $past(phase_pulse));
endmodule

bind sdac_shifter sdac_shifter_chk #(.CH(CH)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .phase_pulse (phase_pulse),
    .busy        (busy),
    .dac_clk     (dac_clk),
    .dac_strobe  (dac_strobe),
    .dac_sdata   (dac_sdata),
    .overrun     (overrun)
);

// File: tb/tb_sdac_shifter.sv
module tb_sdac_shifter;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic [2:0]  div_sel;
    logic        phase_pulse;
    logic [23:0] strobe_pattern;
    logic [95:0] ch_data;
    logic [3:0]  ch_invert;
    logic        dac_clk;
    logic        dac_strobe;
    logic [3:0]  dac_sdata;
    logic        overrun;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    sdac_shifter dut (
        .clk(clk), .rst(rst), .div_sel(div_sel), .phase_pulse(phase_pulse),
        .strobe_pattern(strobe_pattern), .ch_data(ch_data), .ch_invert(ch_invert),
        .dac_clk(dac_clk), .dac_strobe(dac_strobe), .dac_sdata(dac_sdata),
        .overrun(overrun)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%h exp=%h t=%0t", req, got, exp, $time);
        end
    endtask

    task automatic set_div(input logic [2:0] d);
        if (div_sel != d) begin
            div_sel = d;
            repeat (40) @(posedge clk);
            #1;
        end
    endtask

    // R3 R4 R5 R6 R7 R8: one transfer, optional late pulse and late input change
    task automatic xfer(input logic [2:0] d, input logic [23:0] pat,
                        input logic [95:0] dat, input logic [3:0] inv, input bit late);
        logic [4:0] got;
        logic [4:0] exp;
        set_div(d);
        @(negedge clk);
        strobe_pattern = pat;
        ch_data = dat;
        ch_invert = inv;
        phase_pulse = 1'b1;
        @(posedge clk);
        #1;
        phase_pulse = 1'b0;
        @(negedge dac_clk);
        #1;
        if (late) begin
            strobe_pattern = ~pat;
            ch_data = ~dat;
            ch_invert = ~inv;
        end
        for (int i = 0; i < 24; i++) begin
            @(posedge dac_clk);
            #1;
            got = {dac_strobe, dac_sdata};
            exp[4] = pat[23-i];
            for (int c = 0; c < 4; c++) exp[c] = dat[c*24 + 23 - i] ^ inv[c];
            check("R4/R5/R6 bit", 32'(got), 32'(exp));
            if (late && i == 5) begin
                phase_pulse = 1'b1;
                @(posedge clk);
                #1;
                phase_pulse = 1'b0;
            end
        end
        @(negedge dac_clk);
        #1;
        check("R7 low after word", 32'({dac_strobe, dac_sdata}), 32'd0);
        repeat (5) @(posedge clk);
        #1;
        check("R7 low while idle", 32'({dac_strobe, dac_sdata}), 32'd0);
    endtask

    function automatic logic [95:0] mk_data(input int seed);
        logic [95:0] v;
        for (int c = 0; c < 4; c++) v[c*24 +: 24] = 24'(32'h9E3779B1 * (seed * 4 + c + 1));
        return v;
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int t0;
        int t1;
        int t2;
        logic [23:0] pats [6];
        pats[0] = 24'h7FFFC0; pats[1] = 24'hA5A5A5; pats[2] = 24'h800001;
        pats[3] = 24'hFFFFFF; pats[4] = 24'h000000; pats[5] = 24'h3C0F96;
        rst = 1'b1;
        div_sel = 3'd0;
        phase_pulse = 1'b0;
        strobe_pattern = 24'h7FFFC0;
        ch_data = '0;
        ch_invert = '0;
        repeat (3) @(posedge clk);
        #1;
        // R1
        check("R1 reset outputs", 32'({dac_clk, dac_strobe, dac_sdata, overrun}), 32'd0);
        rst = 1'b0;
        #1;

        // R2: period and high time for each divider setting
        for (int d = 0; d < 4; d++) begin
            set_div(3'(d));
            @(posedge dac_clk); t0 = cyc;
            @(negedge dac_clk); t1 = cyc;
            @(posedge dac_clk); t2 = cyc;
            check("R2 period", 32'(t2 - t0), 32'(2 << d));
            check("R2 high time", 32'(t1 - t0), 32'(1 << d));
        end

        // R3-R7: sweep dividers and patterns
        for (int d = 0; d < 3; d++)
            for (int p = 0; p < 6; p++)
                xfer(3'(d), pats[p], mk_data(d * 6 + p), 4'(p * 5 + d), 1'b0);

        // R6: every invert mask
        for (int m = 0; m < 16; m++)
            xfer(3'd0, 24'h7FFFC0, mk_data(100 + m), 4'(m), 1'b0);

        // R9: no overrun yet
        check("R9 overrun clear", 32'(overrun), 32'd0);

        // R8: late pulse and input changes ignored
        xfer(3'd1, 24'h7FFFC0, mk_data(200), 4'b0101, 1'b1);
        check("R8 overrun set", 32'(overrun), 32'd1);
        xfer(3'd0, 24'h5A0FF0, mk_data(201), 4'b1010, 1'b0);
        check("R9 overrun sticky", 32'(overrun), 32'd1);

        // R8: pulse while armed
        rst = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        rst = 1'b0;
        check("R9 overrun cleared by reset", 32'(overrun), 32'd0);
        set_div(3'd3);
        @(posedge dac_clk);
        #1;
        phase_pulse = 1'b1;
        @(posedge clk); #1;
        @(posedge clk); #1;
        phase_pulse = 1'b0;
        check("R8 overrun on armed pulse", 32'(overrun), 32'd1);
        @(negedge dac_clk);
        for (int i = 0; i < 25; i++) @(negedge dac_clk);
        #1;
        check("R7 idle after armed case", 32'({dac_strobe, dac_sdata}), 32'd0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule